// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the byte-addressed program counter of a small processor whose instructions are two bytes long. On each clock edge where the step strobe is high, it loads one of three candidate addresses into the counter. The first is the sequential successor. The second is a PC-relative target, formed by adding a sign-extended offset to the address of the branch itself. The third is an absolute target taken from a register operand. The relative target can be unconditional, or it can depend on a single condition flag.

The block also drives a link value, which is the current counter plus four. A register file can capture it as a return address. Instruction fetch and decode sit outside the block. The decoder supplies the branch kind, the offset, the register operand and the flag, and the fetch logic uses the counter as its address.

Top module: `pcb_branch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` is loaded with 0x0000, and `link_o` then reads 0x0004.
- R2: When `step_i` is low at a rising edge, `pc_o` keeps its value, whatever the branch kind, offset, operand and flag are.
- R3: With `step_i` high and `kind_i` = 0 (sequential), `pc_o` becomes its previous value plus 2.
- R4: With `step_i` high and `kind_i` = 1 (relative), `pc_o` becomes its previous value plus `ofs_i`. The offset is read as a 12-bit two's-complement number, so 0xFF8 means -8 and 0x800 means -2048.
- R5: With `step_i` high, `kind_i` = 2 (relative if flag) and `flag_i` = 1, `pc_o` makes the same relative move as in R4.
- R6: With `step_i` high, `kind_i` = 2 and `flag_i` = 0, `pc_o` advances by 2 and the offset is ignored.
- R7: With `step_i` high and `kind_i` = 3 (absolute), `pc_o` becomes `reg_i` with bit 0 forced to 0.
- R8: `link_o` always equals `pc_o` plus 4, modulo 2^16.
- R9: `flag_i` has no effect for kinds 0, 1 and 3.
- R10: All address arithmetic wraps modulo 2^16. For example, 0xFFFE plus 2 gives 0x0000, and 0x0000 plus -2048 gives 0xF800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance strobe; the counter updates only when this is high |
| kind_i | input | 2 | Branch kind: 0 sequential, 1 relative, 2 relative if flag, 3 absolute |
| ofs_i | input | 12 | Signed relative offset in bytes |
| reg_i | input | 16 | Register operand used as the absolute target |
| flag_i | input | 1 | Condition flag tested by kind 2 |
| pc_o | output | 16 | Current program counter |
| link_o | output | 16 | Return address, equal to pc_o plus 4 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 12-bit offset, a 2-byte step, a link distance of 4 and alignment of absolute targets switched on.

These values bring the following cases within reach:
- the most negative offset, 0x800;
- the most positive even offset, 0x7FE;
- an odd absolute operand;
- wrap-around of the counter at 0xFFFE;
- wrap-around of the link value at the top of the address space.

Each branch kind is driven with both flag values, so both the taken and the not-taken paths of the conditional jump are exercised, and so is the requirement that the flag is ignored for the other kinds.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    // Branch kind as delivered by the decoder.
    typedef enum logic [1:0] {
        BR_STEP   = 2'd0,
        BR_REL    = 2'd1,
        BR_REL_IF = 2'd2,
        BR_ABS    = 2'd3
    } br_kind_e;

    // Source of the next counter value after resolving the condition.
    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_REL = 2'd1,
        SRC_ABS = 2'd2
    } pc_src_e;

    typedef struct packed {
        pc_src_e src;
        logic    load;
    } pc_ctl_t;

    // Turns the branch kind and the flag into a source choice.
    function automatic pc_src_e resolve_src(br_kind_e kind, logic flag);
        pc_src_e s;
        case (kind)
            BR_REL:    s = SRC_REL;
            BR_REL_IF: s = flag ? SRC_REL : SRC_SEQ;
            BR_ABS:    s = SRC_ABS;
            default:   s = SRC_SEQ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pcb_ctl.sv
module pcb_ctl
    import pcb_pkg::*;
(
    input  logic     step_i,
    input  br_kind_e kind_i,
    input  logic     flag_i,
    output pc_ctl_t  ctl_o
);
    always_comb begin
        ctl_o.load = step_i;
        ctl_o.src  = resolve_src(kind_i, flag_i);
    end
endmodule

// File: rtl/pcb_targets.sv
module pcb_targets #(
    parameter int AW         = 16,
    parameter int OW         = 12,
    parameter int STEP_BYTES = 2,
    parameter bit ALIGN_ABS  = 1'b1
) (
    input  logic [AW-1:0] pc_i,
    input  logic [OW-1:0] ofs_i,
    input  logic [AW-1:0] reg_i,
    output logic [AW-1:0] seq_o,
    output logic [AW-1:0] rel_o,
    output logic [AW-1:0] abs_o
);
    localparam int EXT_W = AW - OW;

    logic [AW-1:0] ofs_ext;

    assign ofs_ext = {{EXT_W{ofs_i[OW-1]}}, ofs_i};
    assign seq_o   = pc_i + AW'(STEP_BYTES);
    assign rel_o   = pc_i + ofs_ext;

    generate
        if (ALIGN_ABS) begin : g_align
            assign abs_o = {reg_i[AW-1:1], 1'b0};
        end else begin : g_raw
            assign abs_o = reg_i;
        end
    endgenerate
endmodule

// File: rtl/pcb_pc_reg.sv
module pcb_pc_reg
    import pcb_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          LINK_ADD = 4,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic          clk,
    input  logic          rst,
    input  pc_ctl_t       ctl_i,
    input  logic [AW-1:0] seq_i,
    input  logic [AW-1:0] rel_i,
    input  logic [AW-1:0] abs_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] link_o
);
    logic [AW-1:0] pc_q;
    logic [AW-1:0] nxt;

    always_comb begin
        case (ctl_i.src)
            SRC_REL: nxt = rel_i;
            SRC_ABS: nxt = abs_i;
            default: nxt = seq_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= AW'(RESET_PC);
        else if (ctl_i.load)
            pc_q <= nxt;
    end

    assign pc_o   = pc_q;
    assign link_o = pc_q + AW'(LINK_ADD);

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.load |=> $stable(pc_q)); // R2
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.load |=> $stable(link_o)); // R8
endmodule

// File: rtl/pcb_branch_unit.sv
module pcb_branch_unit
    import pcb_pkg::*;
#(
    parameter int AW         = 16,
    parameter int OW         = 12,
    parameter int STEP_BYTES = 2,
    parameter int LINK_ADD   = 4,
    parameter bit ALIGN_ABS  = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    input  logic [1:0]    kind_i,
    input  logic [OW-1:0] ofs_i,
    input  logic [AW-1:0] reg_i,
    input  logic          flag_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] link_o
);
    br_kind_e      kind;
    pc_ctl_t       ctl;
    logic [AW-1:0] seq_a, rel_a, abs_a;

    assign kind = br_kind_e'(kind_i);

    pcb_ctl u_ctl (
        .step_i (step_i),
        .kind_i (kind),
        .flag_i (flag_i),
        .ctl_o  (ctl)
    );

    pcb_targets #(
        .AW(AW), .OW(OW), .STEP_BYTES(STEP_BYTES), .ALIGN_ABS(ALIGN_ABS)
    ) u_tgt (
        .pc_i  (pc_o),
        .ofs_i (ofs_i),
        .reg_i (reg_i),
        .seq_o (seq_a),
        .rel_o (rel_a),
        .abs_o (abs_a)
    );

    pcb_pc_reg #(
        .AW(AW), .LINK_ADD(LINK_ADD)
    ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .seq_i  (seq_a),
        .rel_i  (rel_a),
        .abs_i  (abs_a),
        .pc_o   (pc_o),
        .link_o (link_o)
    );

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step_i && kind == BR_STEP) |=> pc_o == $past(pc_o) + AW'(STEP_BYTES)); // R3
    AST_COND_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (step_i && kind == BR_REL_IF && !flag_i) |=> pc_o == $past(pc_o) + AW'(STEP_BYTES)); // R6
    AST_ABS_TARGET: assert property (@(posedge clk) disable iff (rst)
        (step_i && kind == BR_ABS) |=> pc_o == ($past(reg_i) & ~AW'(ALIGN_ABS))); // R7
    AST_COND_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (step_i && kind == BR_REL_IF && flag_i) |=>
        pc_o == $past(pc_o) + {{(AW-OW){$past(ofs_i[OW-1])}}, $past(ofs_i)}); // R5
endmodule

// File: tb/test_pcb_branch_unit.sv
`timescale 1ns/1ps
module test_pcb_branch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0;
    logic [1:0]  kind_i = 2'd0;
    logic [11:0] ofs_i = 12'd0;
    logic [15:0] reg_i = 16'd0;
    logic        flag_i = 1'b0;
    logic [15:0] pc_o, link_o;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] mdl_pc = 16'h0000;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    pcb_branch_unit i_pcb_branch_unit (
        .clk(clk), .rst(rst), .step_i(step_i), .kind_i(kind_i),
        .ofs_i(ofs_i), .reg_i(reg_i), .flag_i(flag_i),
        .pc_o(pc_o), .link_o(link_o)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected PC.
    task automatic drive(logic st, logic [1:0] k, logic [11:0] o,
                         logic [15:0] r, logic f, string tag);
        @(negedge clk);
        step_i = st; kind_i = k; ofs_i = o; reg_i = r; flag_i = f;
        if (st) begin
            case (k)
                2'd1: mdl_pc = mdl_pc + {{4{o[11]}}, o};
                2'd2: mdl_pc = f ? mdl_pc + {{4{o[11]}}, o} : mdl_pc + 16'd2;
                2'd3: mdl_pc = {r[15:1], 1'b0};
                default: mdl_pc = mdl_pc + 16'd2;
            endcase
        end
        exp_q.push_back(mdl_pc);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares PC and link shortly after each active edge.
    always @(posedge clk) begin
        #2;
        if (!rst && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, pc_o, e);
            check({t, " R8 link"}, link_o, e + 16'd4);
        end
    end

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc_o, 16'h0000);
        check("R1 reset link", link_o, 16'h0004);
        rst = 1'b0;

        drive(1, 2'd0, 12'h000, 16'h0000, 0, "R3 seq");
        drive(1, 2'd0, 12'h123, 16'h5555, 0, "R3 seq");
        drive(1, 2'd0, 12'h000, 16'h0000, 1, "R3 R9 seq flag");
        drive(0, 2'd1, 12'h100, 16'h0000, 1, "R2 hold rel");
        drive(0, 2'd3, 12'h000, 16'h4444, 0, "R2 hold abs");
        drive(1, 2'd1, 12'h100, 16'h0000, 0, "R4 rel fwd");
        drive(1, 2'd1, 12'hFF8, 16'h0000, 1, "R4 R9 rel back");
        drive(1, 2'd2, 12'h020, 16'h0000, 1, "R5 cond taken");
        drive(1, 2'd2, 12'h020, 16'h0000, 0, "R6 cond not taken");
        drive(1, 2'd3, 12'h000, 16'h1235, 0, "R7 abs odd");
        drive(1, 2'd3, 12'h7FE, 16'hBEEF, 1, "R7 R9 abs flag");
        drive(1, 2'd3, 12'h000, 16'hFFFE, 0, "R7 abs top");
        drive(1, 2'd0, 12'h000, 16'h0000, 0, "R10 seq wrap");
        drive(1, 2'd1, 12'h800, 16'h0000, 0, "R10 rel min");
        drive(1, 2'd1, 12'h7FE, 16'h0000, 0, "R4 rel max");
        drive(0, 2'd0, 12'h000, 16'h0000, 0, "R2 hold");
        drive(1, 2'd0, 12'h000, 16'h0000, 0, "R10 seq wrap2");

        @(negedge clk);
        step_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 re-reset pc", pc_o, 16'h0000);
        check("R1 re-reset link", link_o, 16'h0004);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule